// File: doc/BRIEF.md
# Quad-Channel DAC Double-Buffered Register Front End

This block is the digital side of a four-channel, 12-bit converter with a parallel host bus. Each channel owns two registers. The first is a staging register that the host writes and can read back. The second is a live register whose value drives the converter code. A transfer strobe moves staged values into the live registers. The strobe updates only the addressed channel when it arrives together with a chip-select access, which is single-buffer mode. It updates all four channels at once when it arrives on its own, which is double-buffer mode.

All host pins are treated as asynchronous. They pass through a two-stage synchronizer and are then acted on once per clock cycle. A level that is held therefore keeps its effect for as long as it is held. A clear input overrides every other host input and forces both register banks to zero scale or midscale, chosen by a scale-select pin. The bidirectional data bus is split into a write path, a read path and an output enable, which the pad ring combines.

Top module: `qdac_regfront`

## Requirements
- R1: While `rst_n` is low at a rising edge, all four codes become 0x000 and `bus_oe` becomes 0.
- R2: With `sel_n`=0, `rw_read`=0, `xfer_n`=1 and `clear_n`=1, the bus value is stored in the staging register of channel `reg_addr` (0 to 3 selects channels 0 to 3), and no code changes.
- R3: `bus_oe` is 1 exactly when the synchronized `sel_n`=0, `rw_read`=1 and `clear_n`=1. While it is 1, `bus_rdata` shows the staging register of channel `reg_addr`.
- R4: While `sel_n`=1, no staging register is written, `bus_oe` is 0, and, if `xfer_n`=1, no code changes.
- R5: With `sel_n`=0 and `xfer_n`=0, only the addressed channel's code is loaded from its staging register. When a write is made in the same cycle, the code takes the written bus value directly.
- R6: With `sel_n`=1 and `xfer_n`=0, all four codes load from their staging registers in the same cycle.
- R7: While `clear_n`=0, every staging register and every code becomes 0x800 if `midscale_sel`=1, or 0x000 if `midscale_sel`=0. This overrides any write, read or transfer, and `bus_oe` is 0.
- R8: A change of the inputs takes effect on a code at the third rising edge after the change. It has no effect on the code after only two edges.
- R9: After a clear, a transfer with no new writes leaves every code at the clear value. A read returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sel_n | input | 1 | Chip select, active low, asynchronous |
| rw_read | input | 1 | 1 = read staging register, 0 = write it |
| xfer_n | input | 1 | Transfer strobe, active low, staging to live |
| clear_n | input | 1 | Clear, active low, highest priority |
| midscale_sel | input | 1 | Clear value: 1 = midscale, 0 = zero scale |
| reg_addr | input | 2 | Channel select |
| bus_wdata | input | 12 | Data bus, inbound half |
| bus_rdata | output | 12 | Data bus, outbound half |
| bus_oe | output | 1 | Drive enable for the outbound half |
| dac_codes | output | 48 | Live codes; channel n at bits [12n+11:12n] |

## Verification
Two situations are hard to reach. The first is a clear that arrives while a write and a transfer are in progress. The second is a double-buffer transfer that comes after a clear with no new writes in between, because it only shows whether the staging registers were cleared as well. The stimulus holds a full write cycle that includes the transfer strobe and asserts clear in the same cycle. It then releases clear and sends a lone transfer. The staging contents are then read back through the bus. Latency is probed by sampling one cycle before and one cycle after the expected edge.

// File: rtl/qdac_pkg.sv
// Package: shared sizes and helpers for the quad DAC register front end.
// Assumes a single clock domain. All host pins are asynchronous to it.
package qdac_pkg;
    localparam int CODE_W     = 12;   // converter resolution
    localparam int NUM_CH     = 4;    // channel count
    localparam int SYNC_DEPTH = 2;    // synchronizer stages on host pins

    // Synchronized host controls after the input stage
    typedef struct packed {
        logic sel_n;
        logic rw_read;
        logic xfer_n;
        logic clear_n;
        logic midscale;
    } host_ctrl_t;

    localparam int CTRL_W = $bits(host_ctrl_t);

    // Idle control levels: deselected, write, no transfer, no clear, zero scale
    localparam host_ctrl_t CTRL_IDLE = '{sel_n: 1'b1, rw_read: 1'b0,
                                         xfer_n: 1'b1, clear_n: 1'b1,
                                         midscale: 1'b0};

    // Value placed in both register banks by a clear
    function automatic logic [CODE_W-1:0] clear_value(input logic mid);
        logic [CODE_W-1:0] v;
        v = '0;
        v[CODE_W-1] = mid;
        return v;
    endfunction
endpackage

// File: rtl/qdac_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Each bit has its own reset level, so that idle controls come out
// inactive after reset. Assumes the bits of the bundle are sampled
// together. No skew correction between bits is attempted.
module qdac_sync #(
    parameter int               WIDTH   = 8,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later stages: shift toward the output
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_decode.sv
// Module: decodes synchronized host controls into per-channel strobes.
// The clear input masks every other strobe. Select low together with a
// transfer targets one channel. A transfer alone targets all channels.
module qdac_decode
    import qdac_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  host_ctrl_t     ctrl,
    input  logic [AW-1:0]  addr,
    output logic           clear_en,
    output logic           read_en,
    output logic [NCH-1:0] write_en,
    output logic [NCH-1:0] load_en
);
    logic [NCH-1:0] addr_hot;
    logic           access_ok;
    logic           write_any;
    logic           load_one;
    logic           load_all;

    // Clear has priority; the remaining decode is gated by it
    always_comb begin
        clear_en  = !ctrl.clear_n;
        access_ok = !ctrl.sel_n && !clear_en;
        read_en   = access_ok &&  ctrl.rw_read;
        write_any = access_ok && !ctrl.rw_read;
        load_one  = access_ok && !ctrl.xfer_n;
        load_all  = ctrl.sel_n && !ctrl.xfer_n && !clear_en;
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_lane
            // One-hot address match and the per-lane strobes
            always_comb begin
                addr_hot[c] = (addr == AW'(c));
                write_en[c] = write_any && addr_hot[c];
                load_en[c]  = load_all || (load_one && addr_hot[c]);
            end
        end
    endgenerate
endmodule

// File: rtl/qdac_chan.sv
// Module: one converter channel with a staging register and a live register.
// Assumes the strobes come from qdac_decode, so that clear never coincides
// with write or load. A write in the same cycle as a load passes straight
// through to the live register.
module qdac_chan #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_en,
    input  logic [W-1:0] clear_val,
    input  logic         write_en,
    input  logic         load_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stage_q,
    output logic [W-1:0] live_q
);
    logic [W-1:0] stage_next;

    // Value the staging register holds after this cycle
    always_comb begin
        stage_next = write_en ? wdata : stage_q;
    end

    // Staging register: written by the host, set by clear
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (clear_en) stage_q <= clear_val;
        else               stage_q <= stage_next;
    end

    // Live register: loaded by transfer, set by clear
    always_ff @(posedge clk) begin
        if (!rst_n)        live_q <= '0;
        else if (clear_en) live_q <= clear_val;
        else if (load_en)  live_q <= stage_next;
    end
endmodule

// File: rtl/qdac_rdmux.sv
// Module: read-back multiplexer for the staging registers.
// Output is zero unless a read is decoded, so the bus value is defined
// whenever it is enabled and quiet otherwise.
module qdac_rdmux #(
    parameter int W   = 12,
    parameter int NCH = 4,
    parameter int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH*W-1:0] stage_flat,
    input  logic [AW-1:0]    addr,
    input  logic             read_en,
    output logic [W-1:0]     rdata,
    output logic             oe
);
    // Pick the addressed lane and gate it with the read decode
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (read_en && addr == AW'(i)) rdata = stage_flat[i*W +: W];
        end
        oe = read_en;
    end
endmodule

// File: rtl/qdac_regfront.sv
// Module: top of the quad DAC register front end.
// Synchronizes the host pins, decodes them, and holds the two register
// banks. Every host action lands on the third rising edge after the pins
// change (two synchronizer stages, then the register).
module qdac_regfront
    import qdac_pkg::*;
#(
    parameter int W   = CODE_W,
    parameter int NCH = NUM_CH,
    parameter int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             rw_read,
    input  logic             xfer_n,
    input  logic             clear_n,
    input  logic             midscale_sel,
    input  logic [AW-1:0]    reg_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    output logic             bus_oe,
    output logic [NCH*W-1:0] dac_codes
);
    localparam int BUNDLE_W = CTRL_W + AW + W;
    localparam logic [BUNDLE_W-1:0] BUNDLE_IDLE = {CTRL_IDLE, {AW{1'b0}}, {W{1'b0}}};

    logic [BUNDLE_W-1:0] raw_bundle;
    logic [BUNDLE_W-1:0] syn_bundle;
    host_ctrl_t          ctrl_s;
    logic [AW-1:0]       addr_s;
    logic [W-1:0]        data_s;

    logic                clear_en;
    logic                read_en;
    logic [NCH-1:0]      write_en;
    logic [NCH-1:0]      load_en;
    logic [W-1:0]        clear_val;
    logic [NCH*W-1:0]    stage_flat;

    // Gather the host pins into one bundle for synchronization
    always_comb begin
        raw_bundle = {sel_n, rw_read, xfer_n, clear_n, midscale_sel, reg_addr, bus_wdata};
    end

    qdac_sync #(
        .WIDTH   (BUNDLE_W),
        .STAGES  (SYNC_DEPTH),
        .RST_VAL (BUNDLE_IDLE)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_bundle),
        .q_sync  (syn_bundle)
    );

    // Split the synchronized bundle back into fields
    always_comb begin
        ctrl_s    = host_ctrl_t'(syn_bundle[BUNDLE_W-1 -: CTRL_W]);
        addr_s    = syn_bundle[W +: AW];
        data_s    = syn_bundle[W-1:0];
        clear_val = clear_value(ctrl_s.midscale);
    end

    qdac_decode #(
        .NCH (NCH),
        .AW  (AW)
    ) decode_i (
        .ctrl     (ctrl_s),
        .addr     (addr_s),
        .clear_en (clear_en),
        .read_en  (read_en),
        .write_en (write_en),
        .load_en  (load_en)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            qdac_chan #(
                .W (W)
            ) chan_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear_en  (clear_en),
                .clear_val (clear_val),
                .write_en  (write_en[c]),
                .load_en   (load_en[c]),
                .wdata     (data_s),
                .stage_q   (stage_flat[c*W +: W]),
                .live_q    (dac_codes[c*W +: W])
            );
        end
    endgenerate

    qdac_rdmux #(
        .W   (W),
        .NCH (NCH),
        .AW  (AW)
    ) rdmux_i (
        .stage_flat (stage_flat),
        .addr       (addr_s),
        .read_en    (read_en),
        .rdata      (bus_rdata),
        .oe         (bus_oe)
    );
endmodule

// File: rtl/qdac_regfront_chk.sv
// Checker: temporal properties of qdac_regfront, seen from its ports.
// The past depths of 2 and 3 follow from the fixed two-stage synchronizer
// and the register behind it.
module qdac_regfront_chk #(
    parameter int W   = 12,
    parameter int NCH = 4,
    parameter int AW  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_n,
    input logic             rw_read,
    input logic             xfer_n,
    input logic             clear_n,
    input logic             midscale_sel,
    input logic [W-1:0]     bus_rdata,
    input logic             bus_oe,
    input logic [NCH*W-1:0] dac_codes
);
    logic [2:0]       since_rst;
    logic             ready;
    logic [NCH*W-1:0] prev_codes;
    logic [NCH-1:0]   lane_moved;
    logic [NCH*W-1:0] mid_all;

    // Count cycles out of reset so that $past never reaches into reset
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3'd5) since_rst <= since_rst + 3'd1;
    end

    // Previous codes, to find which lanes moved at the last edge
    always_ff @(posedge clk) begin
        prev_codes <= dac_codes;
    end

    always_comb begin
        ready = (since_rst >= 3'd4);
        for (int i = 0; i < NCH; i++) begin
            lane_moved[i] = (dac_codes[i*W +: W] != prev_codes[i*W +: W]);
        end
        mid_all = '0;
        for (int i = 0; i < NCH; i++) mid_all[i*W + W-1] = 1'b1;
    end

    // R1: reset forces zero codes and a released bus
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_codes == '0) && !bus_oe);

    // R3: the output enable follows select, read and clear two edges late
    assert_oe_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> bus_oe == (!$past(sel_n, 2) && $past(rw_read, 2) && $past(clear_n, 2)));

    // R2 and R4: with no transfer and no clear, no code moves
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready && $past(xfer_n, 3) && $past(clear_n, 3) |-> $stable(dac_codes));

    // R5: a select access moves at most one lane
    assert_single_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !$past(sel_n, 3) && $past(clear_n, 3) |-> $countones(lane_moved) <= 1);

    // R7: clear sets every code to the selected scale
    assert_clear_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !$past(clear_n, 3) |->
            dac_codes == ($past(midscale_sel, 3) ? mid_all : '0));

    // R7: no bus drive while clear is active
    assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !$past(clear_n, 2) |-> !bus_oe);

    // R3: the read path is quiet when not enabled
    assert_rdata_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_rdata == '0);
endmodule

bind qdac_regfront qdac_regfront_chk #(
    .W   (W),
    .NCH (NCH),
    .AW  (AW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n        (sel_n),
    .rw_read      (rw_read),
    .xfer_n       (xfer_n),
    .clear_n      (clear_n),
    .midscale_sel (midscale_sel),
    .bus_rdata    (bus_rdata),
    .bus_oe       (bus_oe),
    .dac_codes    (dac_codes)
);

// File: tb/qdac_regfront_tb.sv
// Bench: vector table for bus accesses and transfers, then directed tests
// for clear, latency and reset.
module qdac_regfront_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 12;
    localparam int NCH = 4;
    localparam int VW  = 44;
    localparam int NV  = 16;

    // Vector: sel_n, rw_read, xfer_n, addr[2], data[12], chk_ch[2], exp_code[12], exp_oe, exp_rd[12]
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0,1'b0,1'b1,2'd0,12'h123, 2'd0,12'h000, 1'b0,12'h000}, // R2 write ch0, no transfer
        {1'b0,1'b1,1'b1,2'd0,12'h000, 2'd0,12'h000, 1'b1,12'h123}, // R3 read ch0
        {1'b1,1'b0,1'b0,2'd0,12'h000, 2'd0,12'h123, 1'b0,12'h000}, // R6 lone transfer
        {1'b0,1'b0,1'b0,2'd1,12'hABC, 2'd1,12'hABC, 1'b0,12'h000}, // R5 write+transfer ch1
        {1'b0,1'b0,1'b1,2'd2,12'h7FF, 2'd2,12'h000, 1'b0,12'h000}, // R2 stage ch2
        {1'b0,1'b0,1'b1,2'd3,12'h800, 2'd3,12'h000, 1'b0,12'h000}, // R2 stage ch3
        {1'b0,1'b1,1'b1,2'd3,12'h000, 2'd2,12'h000, 1'b1,12'h800}, // R3 read ch3
        {1'b1,1'b0,1'b0,2'd0,12'h000, 2'd2,12'h7FF, 1'b0,12'h000}, // R6 all load, ch2
        {1'b1,1'b0,1'b0,2'd0,12'h000, 2'd3,12'h800, 1'b0,12'h000}, // R6 all load, ch3
        {1'b1,1'b0,1'b1,2'd2,12'h555, 2'd2,12'h7FF, 1'b0,12'h000}, // R4 deselected write
        {1'b0,1'b1,1'b1,2'd2,12'h000, 2'd2,12'h7FF, 1'b1,12'h7FF}, // R4 staging untouched
        {1'b1,1'b1,1'b1,2'd2,12'h000, 2'd2,12'h7FF, 1'b0,12'h000}, // R4 deselected read
        {1'b0,1'b1,1'b0,2'd1,12'h000, 2'd1,12'hABC, 1'b1,12'hABC}, // R5 read+transfer ch1
        {1'b0,1'b0,1'b1,2'd0,12'hFFF, 2'd0,12'h123, 1'b0,12'h000}, // R2 restage ch0
        {1'b0,1'b1,1'b0,2'd3,12'h000, 2'd0,12'h123, 1'b1,12'h800}, // R5 other lane held
        {1'b0,1'b1,1'b0,2'd3,12'h000, 2'd3,12'h800, 1'b1,12'h800}  // R5 addressed lane
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sel_n, rw_read, xfer_n, clear_n, midscale_sel;
    logic [1:0]       reg_addr;
    logic [W-1:0]     bus_wdata;
    logic [W-1:0]     bus_rdata;
    logic             bus_oe;
    logic [NCH*W-1:0] dac_codes;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_regfront dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_n        (sel_n),
        .rw_read      (rw_read),
        .xfer_n       (xfer_n),
        .clear_n      (clear_n),
        .midscale_sel (midscale_sel),
        .reg_addr     (reg_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_oe       (bus_oe),
        .dac_codes    (dac_codes)
    );

    function automatic logic [W-1:0] code_of(input int ch);
        return dac_codes[ch*W +: W];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        sel_n = 1'b1; rw_read = 1'b0; xfer_n = 1'b1;
        clear_n = 1'b1; midscale_sel = 1'b0; reg_addr = '0; bus_wdata = '0;
    endtask

    // Three edges for the action to land, then sample at the falling edge
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string req, input logic [W-1:0] exp);
        for (int c = 0; c < NCH; c++) check(req, $sformatf("code ch%0d", c), code_of(c), exp);
    endtask

    initial begin
        drive_idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1", 12'h000);
        check("R1", "bus_oe", {11'd0, bus_oe}, 12'd1 & 12'd0);
        rst_n = 1'b1;
        settle();

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            sel_n = e[43]; rw_read = e[42]; xfer_n = e[41];
            reg_addr = e[40:39]; bus_wdata = e[38:27];
            settle();
            check("R2-R6 table", $sformatf("vec%0d code ch%0d", v, e[26:25]),
                  code_of(int'(e[26:25])), e[24:13]);
            check("R3 table", $sformatf("vec%0d oe", v), {11'd0, bus_oe}, {11'd0, e[12]});
            if (e[12]) check("R3 table", $sformatf("vec%0d rdata", v), bus_rdata, e[11:0]);
            drive_idle();
            settle();
        end

        // R8: latency of a write with transfer on ch2
        @(negedge clk);
        sel_n = 1'b0; xfer_n = 1'b0; reg_addr = 2'd2; bus_wdata = 12'h0F0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8", "ch2 after two edges", code_of(2), 12'h7FF);
        @(posedge clk);
        @(negedge clk);
        check("R8", "ch2 after three edges", code_of(2), 12'h0F0);
        drive_idle();
        settle();

        // R7: midscale clear in the middle of a write with transfer
        sel_n = 1'b0; rw_read = 1'b0; xfer_n = 1'b0; reg_addr = 2'd0;
        bus_wdata = 12'h321; clear_n = 1'b0; midscale_sel = 1'b1;
        settle();
        check_all("R7", 12'h800);
        check("R7", "bus_oe in clear", {11'd0, bus_oe}, 12'd0);
        drive_idle();
        settle();

        // R9: lone transfer after clear keeps the clear value
        xfer_n = 1'b0;
        settle();
        check_all("R9", 12'h800);
        drive_idle();
        settle();
        sel_n = 1'b0; rw_read = 1'b1; reg_addr = 2'd2;
        settle();
        check("R9", "read ch2 after clear", bus_rdata, 12'h800);

        // R7: zero-scale clear during a read, with transfer held
        clear_n = 1'b0; midscale_sel = 1'b0; reg_addr = 2'd1; xfer_n = 1'b0;
        settle();
        check_all("R7", 12'h000);
        check("R7", "bus_oe during read under clear", {11'd0, bus_oe}, 12'd0);
        clear_n = 1'b1; xfer_n = 1'b1;
        settle();
        check("R9", "read ch1 after zero clear", bus_rdata, 12'h000);
        check("R3", "bus_oe after clear released", {11'd0, bus_oe}, 12'd1);
        drive_idle();
        xfer_n = 1'b0;
        settle();
        check_all("R9", 12'h000);
        drive_idle();

        // R1: reset in operation after a nonzero load
        sel_n = 1'b0; xfer_n = 1'b0; reg_addr = 2'd3; bus_wdata = 12'h9A5;
        settle();
        check("R5", "ch3 before reset", code_of(3), 12'h9A5);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_all("R1", 12'h000);
        rst_n = 1'b1;
        drive_idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule